// File: doc/BRIEF.md
# Signature-Compacting SRAM Self-Test Engine

This block tests a single-port SRAM without storing any expected read data. It drives the memory through a fixed sequence of eight sweeps. Each sweep covers the whole address range before the next one begins. Writes use the word's own address as data, or the bitwise inverse of that address. Every word read back is folded into a multiple-input signature register (MISR) as wide as the data word. At the end of a pass, the accumulated signature is compared with a golden value that the integrator supplies as a parameter.

A full run is two passes. The first pass walks addresses upward and uses the first feedback polynomial. The second pass walks addresses downward and uses the second polynomial. A fault that happens to alias to the golden signature in one pass is then unlikely to alias in the other. A one-cycle `start` pulse launches a run. `done` rises once both passes have finished, and `ok` reports whether both signatures matched.

The memory port is a plain synchronous SRAM port, not a stream. It has no valid/ready handshake because the engine never stalls and the memory cannot push back. The memory must accept one operation on every cycle that `mem_req` is high, and it must return read data on `mem_rdata` exactly one cycle after a read request. The data width must be at least the address width.

Top module: `mbist_misr_top`

## Requirements
- R1: After reset, `done`, `ok` and `mem_req` are low and `sig_final` is all zeros.
- R2: A pass is eight sweeps, in this order: write true data; read; write inverted data; read; read; write true data; read; read. True data is the address zero-extended to the data width, and inverted data is its bitwise complement over the full word. Each sweep issues one operation per cycle over all 2^AW addresses before the next sweep starts.
- R3: Pass 0 visits addresses 0 up to 2^AW-1 in every sweep, and pass 1 visits 2^AW-1 down to 0. Between the two passes, and after pass 1, there are exactly two cycles with `mem_req` low.
- R4: The signature is cleared to zero at the start of each pass. It changes only on the cycle after a read request, becoming {sig[DW-2:0],0} XOR (sig[DW-1] ? poly : 0) XOR `mem_rdata`.
- R5: Pass 0 folds with `POLY_A` and pass 1 folds with `POLY_B`.
- R6: When both passes are over, `done` goes high and stays high until the next accepted start. At that point `sig_final[DW-1:0]` holds the pass 0 signature and `sig_final[2*DW-1:DW]` holds the pass 1 signature. Both stay stable while `done` is high.
- R7: A `start` pulse that arrives while a run is in progress is ignored. The run ends on its original schedule, 2*(8*2^AW+2) cycles after the first run cycle, with its normal results.
- R8: A `start` accepted while `done` is high begins a fresh run. `done` drops at once, and the earlier run leaves no trace in the new signatures.
- R9: `ok` is high with `done` only if each pass's signature equals its golden value (`GOLD_A`, `GOLD_B`). A stuck-at bit in any cell makes `ok` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launches a run when idle or done |
| mem_req | output | 1 | Memory operation this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Write data (zero when not writing) |
| mem_rdata | input | DW | Read data, one cycle after a read request |
| done | output | 1 | Run finished; held until the next start |
| ok | output | 1 | Both signatures matched their golden values |
| sig_final | output | 2*DW | Final signatures: pass 1 in the upper half, pass 0 in the lower half |

## Verification
The bench follows every memory operation of a run against its own model of the sweep order. This exposes an engine that reverses only some sweeps, skips the inverted data, or lets sweeps overlap, because the address or write data would then differ from the model on some cycle. It computes golden and faulty signatures from its own RAM model, with a stuck-at-1 and a stuck-at-0 cell injected. A MISR that folded on the wrong cycle, used the wrong polynomial in a pass, or was not reseeded between passes would produce a signature that disagrees with the model. A start pulse in mid-run is checked against the exact cycle on which `done` must rise, so a restart would show up as a late `done`. A rerun after a faulty run must again report `ok` with the golden signatures, which catches results carried over between runs.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  localparam int NUM_ELEM = 8;
  localparam int NUM_PASS = 2;
  localparam int ELEM_W   = $clog2(NUM_ELEM);

  typedef enum logic [1:0] {
    OP_WR_TRUE = 2'd0,
    OP_WR_INV  = 2'd1,
    OP_RD      = 2'd2
  } mem_op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RUN   = 3'd1,
    ST_DRAIN = 3'd2,
    ST_CHECK = 3'd3,
    ST_DONE  = 3'd4
  } bist_state_e;

  // Operation carried out by each sweep of a pass (order is behaviour).
  function automatic mem_op_e element_op(input logic [ELEM_W-1:0] e);
    mem_op_e op;
    case (e)
      3'd0:    op = OP_WR_TRUE;
      3'd2:    op = OP_WR_INV;
      3'd5:    op = OP_WR_TRUE;
      default: op = OP_RD;
    endcase
    return op;
  endfunction

endpackage

// File: rtl/mbist_addr_gen.sv
module mbist_addr_gen #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  input  logic          descend,
  output logic [AW-1:0] addr,
  output logic          last
);

  logic [AW-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx_q <= '0;
    else if (clear) idx_q <= '0;
    else if (step)  idx_q <= idx_q + 1'b1;  // wraps to 0 after the last index
  end

  // Reversed order over a power-of-two range is the bitwise inverse of the index.
  assign addr = descend ? ~idx_q : idx_q;
  assign last = &idx_q;

  assert_addr_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear && !last && !descend) |=> (addr == $past(addr) + 1'b1));

  assert_addr_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear && !last && descend) |=> (addr == $past(addr) - 1'b1));

endmodule

// File: rtl/mbist_misr.sv
module mbist_misr #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          upd,
  input  logic [DW-1:0] poly,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] sig
);

  logic [DW-1:0] sig_q;
  logic [DW-1:0] sig_d;
  logic          fb;

  assign fb = sig_q[DW-1];

  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign sig_d[i] = (poly[i] & fb) ^ din[i];
    end else begin : g_upper
      assign sig_d[i] = sig_q[i-1] ^ (poly[i] & fb) ^ din[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sig_q <= '0;
    else if (clear) sig_q <= '0;
    else if (upd)   sig_q <= sig_d;
  end

  assign sig = sig_q;

  assert_misr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !upd) |=> (sig == $past(sig)));

  assert_misr_seed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (sig == '0));

endmodule

// File: rtl/mbist_ctrl.sv
module mbist_ctrl
  import mbist_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] addr,
  input  logic          addr_last,
  output logic          gen_clear,
  output logic          gen_step,
  output logic          descend,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  output logic          rd_valid,
  output logic          misr_clear,
  output logic          check_now,
  output logic          check_pass,
  output logic          launch,
  output logic          done
);

  bist_state_e       state_q, state_d;
  logic [ELEM_W-1:0] elem_q, elem_d;
  logic              pass_q, pass_d;
  logic              rd_q;
  mem_op_e           op;
  logic [DW-1:0]     addr_word;

  if (DW > AW) begin : g_pad
    assign addr_word = {{(DW-AW){1'b0}}, addr};
  end else begin : g_flat
    assign addr_word = addr;
  end

  always_comb begin
    state_d    = state_q;
    elem_d     = elem_q;
    pass_d     = pass_q;
    gen_clear  = 1'b0;
    gen_step   = 1'b0;
    misr_clear = 1'b0;
    check_now  = 1'b0;
    launch     = 1'b0;
    case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          launch     = 1'b1;
          state_d    = ST_RUN;
          elem_d     = '0;
          pass_d     = 1'b0;
          gen_clear  = 1'b1;
          misr_clear = 1'b1;
        end
      end
      ST_RUN: begin
        gen_step = 1'b1;
        if (addr_last) begin
          if (elem_q == ELEM_W'(NUM_ELEM - 1)) state_d = ST_DRAIN;
          else                                  elem_d  = elem_q + 1'b1;
        end
      end
      ST_DRAIN: state_d = ST_CHECK;
      ST_CHECK: begin
        check_now = 1'b1;
        if (!pass_q) begin
          pass_d     = 1'b1;
          elem_d     = '0;
          state_d    = ST_RUN;
          misr_clear = 1'b1;
        end else begin
          state_d = ST_DONE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      elem_q  <= '0;
      pass_q  <= 1'b0;
      rd_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      elem_q  <= elem_d;
      pass_q  <= pass_d;
      rd_q    <= mem_req && !mem_we;
    end
  end

  assign op         = element_op(elem_q);
  assign mem_req    = (state_q == ST_RUN);
  assign mem_we     = mem_req && (op != OP_RD);
  assign mem_wdata  = !mem_we ? '0 : ((op == OP_WR_INV) ? ~addr_word : addr_word);
  assign rd_valid   = rd_q;
  assign descend    = pass_q;
  assign check_pass = pass_q;
  assign done       = (state_q == ST_DONE);

  // Each new sweep begins at the first address of the pass direction.
  assert_sweep_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && $past(state_q) == ST_RUN && elem_q != $past(elem_q))
      |-> ((pass_q && addr == {AW{1'b1}}) || (!pass_q && addr == '0)));

  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && start && !addr_last)
      |=> (state_q == ST_RUN && elem_q == $past(elem_q) && pass_q == $past(pass_q)));

  assert_gap_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CHECK) |-> ($past(state_q) == ST_DRAIN && !mem_req));

endmodule

// File: rtl/mbist_misr_top.sv
module mbist_misr_top
  import mbist_pkg::*;
#(
  parameter int            AW     = 4,
  parameter int            DW     = 8,
  parameter logic [DW-1:0] POLY_A = 'h1D,
  parameter logic [DW-1:0] POLY_B = 'h4D,
  parameter logic [DW-1:0] GOLD_A = '0,
  parameter logic [DW-1:0] GOLD_B = '0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [AW-1:0]          mem_addr,
  output logic [DW-1:0]          mem_wdata,
  input  logic [DW-1:0]          mem_rdata,
  output logic                   done,
  output logic                   ok,
  output logic [NUM_PASS*DW-1:0] sig_final
);

  localparam logic [DW-1:0] POLY_TBL [NUM_PASS] = '{POLY_A, POLY_B};
  localparam logic [DW-1:0] GOLD_TBL [NUM_PASS] = '{GOLD_A, GOLD_B};

  logic          gen_clear, gen_step, descend, addr_last;
  logic          rd_valid, misr_clear, check_now, check_pass, launch;
  logic [DW-1:0] misr_sig;
  logic [DW-1:0] slot_q [NUM_PASS];
  logic          fail_q;

  mbist_addr_gen #(.AW(AW)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (gen_clear),
    .step    (gen_step),
    .descend (descend),
    .addr    (mem_addr),
    .last    (addr_last)
  );

  mbist_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .addr       (mem_addr),
    .addr_last  (addr_last),
    .gen_clear  (gen_clear),
    .gen_step   (gen_step),
    .descend    (descend),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata),
    .rd_valid   (rd_valid),
    .misr_clear (misr_clear),
    .check_now  (check_now),
    .check_pass (check_pass),
    .launch     (launch),
    .done       (done)
  );

  mbist_misr #(.DW(DW)) u_misr (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (misr_clear),
    .upd   (rd_valid),
    .poly  (POLY_TBL[descend]),
    .din   (mem_rdata),
    .sig   (misr_sig)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_PASS; p++) slot_q[p] <= '0;
      fail_q <= 1'b0;
    end else if (launch) begin
      for (int p = 0; p < NUM_PASS; p++) slot_q[p] <= '0;
      fail_q <= 1'b0;
    end else if (check_now) begin
      slot_q[check_pass] <= misr_sig;
      if (misr_sig != GOLD_TBL[check_pass]) fail_q <= 1'b1;
    end
  end

  for (genvar p = 0; p < NUM_PASS; p++) begin : g_out
    assign sig_final[p*DW +: DW] = slot_q[p];
  end

  assign ok = done && !fail_q;

  assert_fold_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(misr_sig) |-> $past(rd_valid || misr_clear));

  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(sig_final) && ok == $past(ok)));

endmodule

// File: tb/mbist_misr_top_test.sv
module mbist_misr_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int N  = 1 << AW;
  localparam int RUN_CYCLES = 2 * (8 * N + 2);
  localparam logic [DW-1:0] POLY_A = 8'h1D;
  localparam logic [DW-1:0] POLY_B = 8'h4D;

  // Sweep kinds: 0 = write true data, 1 = read, 2 = write inverted data (R2)
  function automatic int ref_kind(input int e);
    case (e)
      0, 5:    return 0;
      2:       return 2;
      default: return 1;
    endcase
  endfunction

  function automatic logic [DW-1:0] ref_sig(input int p, input bit st, input int sa,
                                           input int sb, input bit sv);
    logic [N*DW-1:0] ram;
    logic [DW-1:0]   sig, d, poly;
    int              a;
    ram  = '0;
    sig  = '0;
    poly = (p == 0) ? POLY_A : POLY_B;
    for (int e = 0; e < 8; e++) begin
      for (int i = 0; i < N; i++) begin
        a = (p == 0) ? i : N - 1 - i;
        if (ref_kind(e) != 1) begin
          d = DW'(a);
          if (ref_kind(e) == 2) d = ~d;
          if (st && a == sa) d[sb] = sv;
          ram[a*DW +: DW] = d;
        end else begin
          d   = ram[a*DW +: DW];
          sig = {sig[DW-2:0], 1'b0} ^ (sig[DW-1] ? poly : '0) ^ d;
        end
      end
    end
    return sig;
  endfunction

  localparam logic [DW-1:0] GOLD_A = ref_sig(0, 1'b0, 0, 0, 1'b0);
  localparam logic [DW-1:0] GOLD_B = ref_sig(1, 1'b0, 0, 0, 1'b0);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic            mem_req, mem_we, done, ok;
  logic [AW-1:0]   mem_addr;
  logic [DW-1:0]   mem_wdata;
  logic [DW-1:0]   mem_rdata = '0;
  logic [2*DW-1:0] sig_final;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  bit  st_en = 1'b0;
  int  st_addr = 0;
  int  st_bit = 0;
  bit  st_val = 1'b0;
  logic [DW-1:0] ram [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  mbist_misr_top #(
    .AW(AW), .DW(DW), .POLY_A(POLY_A), .POLY_B(POLY_B), .GOLD_A(GOLD_A), .GOLD_B(GOLD_B)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .done(done), .ok(ok), .sig_final(sig_final)
  );

  function automatic logic [DW-1:0] inj(input logic [DW-1:0] d, input logic [AW-1:0] a);
    logic [DW-1:0] r;
    r = d;
    if (st_en && int'(a) == st_addr) r[st_bit] = st_val;
    return r;
  endfunction

  // RAM model, one-cycle read latency
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) ram[mem_addr] <= inj(mem_wdata, mem_addr);
      else        mem_rdata     <= inj(ram[mem_addr], mem_addr);
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 2 * RUN_CYCLES) begin
      @(negedge clk);
      n++;
    end
  endtask

  // Follows every operation of a run; ends on the first done cycle
  task automatic watch_run(output int m0, output int m1, output int gap);
    m0 = 0; m1 = 0; gap = 0;
    for (int p = 0; p < 2; p++) begin
      for (int e = 0; e < 8; e++) begin
        for (int i = 0; i < N; i++) begin
          int a;
          bit we;
          logic [DW-1:0] wd;
          a  = (p == 0) ? i : N - 1 - i;
          we = (ref_kind(e) != 1);
          wd = DW'(a);
          if (ref_kind(e) == 2) wd = ~wd;
          if (!mem_req || int'(mem_addr) != a || mem_we !== we || (we && mem_wdata !== wd)) begin
            if (p == 0) m0++; else m1++;
          end
          @(negedge clk);
        end
      end
      for (int g = 0; g < 2; g++) begin
        if (mem_req !== 1'b0) gap++;
        @(negedge clk);
      end
    end
  endtask

  task automatic t_reset();
    chk("R1 done after reset", done, 0);
    chk("R1 ok after reset", ok, 0);
    chk("R1 mem_req after reset", mem_req, 0);
    chk("R1 sig_final after reset", sig_final, 0);
  endtask

  task automatic t_clean();
    int m0, m1, gap;
    st_en = 1'b0;
    pulse_start();
    watch_run(m0, m1, gap);
    chk("R2 pass0 op sequence mismatches", m0, 0);
    chk("R3 pass1 descending op mismatches", m1, 0);
    chk("R3 idle gap cycles with mem_req", gap, 0);
    chk("R6 done at end of run", done, 1);
    chk("R9 ok for fault-free RAM", ok, 1);
    chk("R4 pass0 signature", sig_final[DW-1:0], GOLD_A);
    chk("R5 pass1 signature with second polynomial", sig_final[2*DW-1:DW], GOLD_B);
    repeat (5) @(negedge clk);
    chk("R6 done held", done, 1);
  endtask

  task automatic t_stuck(input int sa, input int sb, input bit sv);
    st_en = 1'b1; st_addr = sa; st_bit = sb; st_val = sv;
    pulse_start();
    wait_done();
    chk("R9 ok low with stuck cell", ok, 0);
    chk("R4 faulty pass0 signature", sig_final[DW-1:0], ref_sig(0, 1'b1, sa, sb, sv));
    chk("R5 faulty pass1 signature", sig_final[2*DW-1:DW], ref_sig(1, 1'b1, sa, sb, sv));
    chk("R9 faulty signature differs from golden",
        (sig_final[DW-1:0] != GOLD_A) && (sig_final[2*DW-1:DW] != GOLD_B), 1);
    st_en = 1'b0;
  endtask

  task automatic t_rerun();
    st_en = 1'b0;
    pulse_start();
    chk("R8 done drops on restart", done, 0);
    wait_done();
    chk("R8 ok after rerun", ok, 1);
    chk("R8 pass0 signature reseeded", sig_final[DW-1:0], GOLD_A);
    chk("R8 pass1 signature reseeded", sig_final[2*DW-1:DW], GOLD_B);
  endtask

  task automatic t_start_ignored();
    st_en = 1'b0;
    pulse_start();
    repeat (37) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (RUN_CYCLES - 38 - 1) @(negedge clk);
    chk("R7 done not early", done, 0);
    @(negedge clk);
    chk("R7 done on original schedule", done, 1);
    chk("R7 ok unaffected", ok, 1);
    chk("R7 signatures unaffected", sig_final, {GOLD_B, GOLD_A});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_stuck(5, 0, 1'b1);
    t_rerun();
    t_stuck(0, DW - 1, 1'b0);
    t_start_ignored();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule